// File: doc/BRIEF.md
# Channel Attention Command Controller

This block sits between the channel-attention strobe of a network controller and its command-list executor. Each channel-attention pulse makes it take in the 16-bit control command word that was fetched from shared memory. It splits that word into a command-unit field and a receive-unit field and updates the two unit states. It clears the event bits that the host acknowledges, may apply a soft reset, and may load the command-list pointer from the list-head value. It then asks for the command word to be written back as zero and presents a composed 16-bit status word with a write strobe.

Pulses that arrive while a command is being handled are not dropped. They are counted, and the block serves each of them in turn. Two event bits, command complete and frame received, are set by strobes from the neighbouring units. Those strobes also raise an interrupt level that stays high until the host clears it. When the command unit is active and a valid list pointer is held, the block sends a start request to the executor.

Top module: `chanatt_ctrl`

## Requirements
- R1: After reset the status word reads 0x0010 (command unit idle, receive unit suspended, no events), the list pointer is all ones (null), and irq, statusWe, cmdClrWe and startReq are low.
- R2: Command word bits 10:8 carry the command-unit command. Code 1 sets the command-unit state to active (2). Code 4 sets it to suspended (1) and sets event bit 13. Code 0 changes nothing.
- R3: Command word bits 6:4 carry the receive-unit command. Codes 1 and 2 set the receive-unit state to idle (0). Codes 3 and 4 set it to suspended (1) and set event bit 12. Code 0 changes nothing.
- R4: Each set bit among command word bits 15:12 clears the event bit at the same position. This clearing happens before any event that the same command raises.
- R5: The status word holds the events in bits 15:12, the command-unit state in bits 10:8 and the receive-unit state in bits 6:4. All other bits are zero.
- R6: Command word bit 7 causes a soft reset, which takes effect after the field decode. The command unit goes idle, the receive unit goes suspended, all events and irq are cleared, the pointer becomes null, and softRst pulses high for one cycle together with statusWe.
- R7: After each decode, if the command unit is not suspended and the pointer is null, the pointer is loaded from listHead. Otherwise it keeps its value. ptrRelease, pulsed while no command is being decoded, returns the pointer to null.
- R8: Every caPulse is served exactly once, including pulses that arrive back to back or during processing. Each service produces one statusWe pulse.
- R9: A service drives cmdClrWe for one cycle, and statusWe follows in the next cycle. For a pulse that arrives while the block is idle, cmdClrWe is high in the second cycle after the pulse.
- R10: A command-unit code other than 0, 1 or 4, or a receive-unit code of 5 to 7, leaves that unit's state unchanged and raises errPulse for one cycle together with statusWe.
- R11: A cxEvent or frEvent strobe sets irq. irq stays high until irqClr or a soft reset clears it.
- R12: startReq is high only in the statusWe cycle, and only when the command-unit state is active and the pointer is not null.
- R13: A cxEvent strobe sets event bit 15 and a frEvent strobe sets event bit 14. Both bits stay set until they are acknowledged or a soft reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| caPulse | input | 1 | Channel-attention strobe |
| cmdWord | input | 16 | Command word fetched from memory, held during service |
| listHead | input | PTR_W | List-head pointer fetched from memory |
| cxEvent | input | 1 | Command completed with interrupt request |
| frEvent | input | 1 | Frame received |
| irqClr | input | 1 | Host clears the interrupt level |
| ptrRelease | input | 1 | Executor finished the list; pointer returns to null |
| cmdClrWe | output | 1 | Write the command word back as zero |
| statusWe | output | 1 | Write strobe for statusWord |
| statusWord | output | 16 | Composed status word |
| cmdPtr | output | PTR_W | Current command-list pointer (all ones = null) |
| startReq | output | 1 | Start request to the command-list executor |
| softRst | output | 1 | One-cycle soft-reset indication |
| errPulse | output | 1 | One-cycle unknown-command indication |
| irq | output | 1 | Interrupt request level |

## Verification
The bench sends bursts of channel-attention pulses on consecutive cycles. A controller that lost a pulse while busy would produce fewer status writes than pulses. Commands that acknowledge an event and raise a new one in the same word check the ordering: applying the clear last would wipe out the new event. A soft reset combined with a command-unit start checks that the reset wins and that the pointer is reloaded right after being nulled. Unknown codes must leave the states untouched. Random commands with a suspended command unit and a null pointer catch a design that loads the pointer when it must not.

// File: rtl/chanatt_pkg.sv
package chanatt_pkg;
  localparam logic [2:0] CU_IDLE   = 3'd0;
  localparam logic [2:0] CU_SUSP   = 3'd1;
  localparam logic [2:0] CU_ACTIVE = 3'd2;
  localparam logic [2:0] RU_IDLE   = 3'd0;
  localparam logic [2:0] RU_SUSP   = 3'd1;
  localparam logic [2:0] RU_READY  = 3'd4;

  // event vector index: [3]=bit15 ... [0]=bit12
  localparam int EV_CX  = 3;
  localparam int EV_FR  = 2;
  localparam int EV_CNA = 1;
  localparam int EV_RNR = 0;

  typedef struct packed {
    logic decode;   // command word is being decoded this cycle
    logic publish;  // status word is being written this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/chanatt_ctl.sv
module chanatt_ctl
  import chanatt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       caPulse,
  output ctlStrobe_t strb
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_PUBLISH} ctlState_e;

  ctlState_e        state, stateNext;
  logic [CNT_W-1:0] caCnt, caCntNext;
  logic             takeOne;

  always_comb begin
    takeOne   = (state == ST_IDLE) && (caCnt != '0);
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (takeOne) stateNext = ST_DECODE;
      ST_DECODE:  stateNext = ST_PUBLISH;
      ST_PUBLISH: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    caCntNext = caCnt;
    if (caPulse && !takeOne && caCnt != CNT_MAX) caCntNext = caCnt + 1'b1;
    else if (!caPulse && takeOne)                caCntNext = caCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      caCnt <= '0;
    end else begin
      state <= stateNext;
      caCnt <= caCntNext;
    end
  end

  assign strb.decode  = (state == ST_DECODE);
  assign strb.publish = (state == ST_PUBLISH);
endmodule

// File: rtl/chanatt_dp.sv
module chanatt_dp
  import chanatt_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [15:0]      cmdWord,
  input  logic [PTR_W-1:0] listHead,
  input  logic             cxEvent,
  input  logic             frEvent,
  input  logic             irqClr,
  input  logic             ptrRelease,
  output logic [15:0]      statusWord,
  output logic [PTR_W-1:0] cmdPtr,
  output logic             startReq,
  output logic             softRst,
  output logic             errPulse,
  output logic             irq
);
  localparam logic [PTR_W-1:0] PTR_NULL = {PTR_W{1'b1}};

  logic [2:0]       cuSt, cuNext, ruSt, ruNext;
  logic [3:0]       evt, evtNext;
  logic [PTR_W-1:0] ptr, ptrNext;
  logic             irqQ, irqNext, errQ, errNext, rstQ, rstNext;
  logic [2:0]       cuCode, ruCode;

  assign cuCode = cmdWord[10:8];
  assign ruCode = cmdWord[6:4];

  always_comb begin
    cuNext  = cuSt;
    ruNext  = ruSt;
    evtNext = evt;
    ptrNext = ptr;
    irqNext = irqQ;
    errNext = 1'b0;
    rstNext = 1'b0;
    if (strb.decode) begin
      evtNext = evt & ~cmdWord[15:12];
      unique case (cuCode)
        3'd0: ;
        3'd1: cuNext = CU_ACTIVE;
        3'd4: begin cuNext = CU_SUSP; evtNext[EV_CNA] = 1'b1; end
        default: errNext = 1'b1;
      endcase
      unique case (ruCode)
        3'd0: ;
        3'd1, 3'd2: ruNext = RU_IDLE;
        3'd3, 3'd4: begin ruNext = RU_SUSP; evtNext[EV_RNR] = 1'b1; end
        default: errNext = 1'b1;
      endcase
    end else if (ptrRelease) begin
      ptrNext = PTR_NULL;
    end
    evtNext[EV_CX] = evtNext[EV_CX] | cxEvent;
    evtNext[EV_FR] = evtNext[EV_FR] | frEvent;
    if (cxEvent || frEvent) irqNext = 1'b1;
    else if (irqClr)        irqNext = 1'b0;
    if (strb.decode && cmdWord[7]) begin
      cuNext  = CU_IDLE;
      ruNext  = RU_SUSP;
      evtNext = '0;
      ptrNext = PTR_NULL;
      irqNext = 1'b0;
      rstNext = 1'b1;
    end
    if (strb.decode && cuNext != CU_SUSP && ptrNext == PTR_NULL)
      ptrNext = listHead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cuSt <= CU_IDLE;
      ruSt <= RU_SUSP;
      evt  <= '0;
      ptr  <= PTR_NULL;
      irqQ <= 1'b0;
      errQ <= 1'b0;
      rstQ <= 1'b0;
    end else begin
      cuSt <= cuNext;
      ruSt <= ruNext;
      evt  <= evtNext;
      ptr  <= ptrNext;
      irqQ <= irqNext;
      errQ <= errNext;
      rstQ <= rstNext;
    end
  end

  assign statusWord = {evt, 1'b0, cuSt, 1'b0, ruSt, 4'b0000};
  assign cmdPtr     = ptr;
  assign startReq   = strb.publish && (cuSt == CU_ACTIVE) && (ptr != PTR_NULL);
  assign softRst    = rstQ;
  assign errPulse   = errQ;
  assign irq        = irqQ;
endmodule

// File: rtl/chanatt_ctrl.sv
module chanatt_ctrl
  import chanatt_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             caPulse,
  input  logic [15:0]      cmdWord,
  input  logic [PTR_W-1:0] listHead,
  input  logic             cxEvent,
  input  logic             frEvent,
  input  logic             irqClr,
  input  logic             ptrRelease,
  output logic             cmdClrWe,
  output logic             statusWe,
  output logic [15:0]      statusWord,
  output logic [PTR_W-1:0] cmdPtr,
  output logic             startReq,
  output logic             softRst,
  output logic             errPulse,
  output logic             irq
);
  ctlStrobe_t strb;

  chanatt_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .caPulse(caPulse), .strb(strb)
  );

  chanatt_dp #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWord(cmdWord),
    .listHead(listHead), .cxEvent(cxEvent), .frEvent(frEvent),
    .irqClr(irqClr), .ptrRelease(ptrRelease), .statusWord(statusWord),
    .cmdPtr(cmdPtr), .startReq(startReq), .softRst(softRst),
    .errPulse(errPulse), .irq(irq)
  );

  assign cmdClrWe = strb.decode;
  assign statusWe = strb.publish;
endmodule

// File: rtl/chanatt_chk.sv
module chanatt_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [15:0]      cmdWord,
  input logic             cxEvent,
  input logic             irqClr,
  input logic             cmdClrWe,
  input logic             statusWe,
  input logic [15:0]      statusWord,
  input logic [PTR_W-1:0] cmdPtr,
  input logic             startReq,
  input logic             errPulse,
  input logic             softRst,
  input logic             irq
);
  a_r9_clr_then_status: assert property (@(posedge clk) disable iff (!rstN)
    cmdClrWe |=> statusWe);

  a_r9_status_after_clr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWe) |-> $past(cmdClrWe));

  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    cmdClrWe |=> !cmdClrWe);

  a_r10_err_with_status: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> statusWe);

  a_r6_reset_with_status: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> (statusWe && statusWord[15:12] == 4'h0 && statusWord[6:4] == 3'd1));

  a_r12_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> (statusWe && statusWord[10:8] == 3'd2 && cmdPtr != {PTR_W{1'b1}}));

  a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> ($past(irqClr) || $past(cmdClrWe && cmdWord[7])));

  a_r13_cx_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cxEvent && !cmdClrWe) |=> statusWord[15]);

  a_r5_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[11] == 1'b0 && statusWord[7] == 1'b0 && statusWord[3:0] == 4'h0);
endmodule

bind chanatt_ctrl chanatt_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWord(cmdWord), .cxEvent(cxEvent),
  .irqClr(irqClr), .cmdClrWe(cmdClrWe), .statusWe(statusWe),
  .statusWord(statusWord), .cmdPtr(cmdPtr), .startReq(startReq),
  .errPulse(errPulse), .softRst(softRst), .irq(irq)
);

// File: tb/chanatt_ctrl_tb.sv
module chanatt_ctrl_tb;
  localparam int PTR_W = 32;
  localparam logic [PTR_W-1:0] NUL = {PTR_W{1'b1}};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             caPulse = 1'b0;
  logic [15:0]      cmdWord = '0;
  logic [PTR_W-1:0] listHead = '0;
  logic             cxEvent = 1'b0, frEvent = 1'b0, irqClr = 1'b0, ptrRelease = 1'b0;
  logic             cmdClrWe, statusWe, startReq, softRst, errPulse, irq;
  logic [15:0]      statusWord;
  logic [PTR_W-1:0] cmdPtr;

  always #5 clk = ~clk;

  chanatt_ctrl #(.PTR_W(PTR_W), .CNT_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .caPulse(caPulse), .cmdWord(cmdWord),
    .listHead(listHead), .cxEvent(cxEvent), .frEvent(frEvent),
    .irqClr(irqClr), .ptrRelease(ptrRelease), .cmdClrWe(cmdClrWe),
    .statusWe(statusWe), .statusWord(statusWord), .cmdPtr(cmdPtr),
    .startReq(startReq), .softRst(softRst), .errPulse(errPulse), .irq(irq)
  );

  int nChk = 0, nFail = 0;
  // reference model
  logic [2:0] mCu, mRu;
  logic [3:0] mEvt;
  logic [PTR_W-1:0] mPtr;
  logic mIrq, mErr, mRst;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mStatus();
    return {mEvt, 1'b0, mCu, 1'b0, mRu, 4'b0};
  endfunction

  task automatic modelCmd(input logic [15:0] c, input logic [PTR_W-1:0] head);
    mErr = 1'b0;
    mRst = c[7];
    mEvt = mEvt & ~c[15:12];
    case (c[10:8])
      3'd0: ;
      3'd1: mCu = 3'd2;
      3'd4: begin mCu = 3'd1; mEvt[1] = 1'b1; end
      default: mErr = 1'b1;
    endcase
    case (c[6:4])
      3'd0: ;
      3'd1, 3'd2: mRu = 3'd0;
      3'd3, 3'd4: begin mRu = 3'd1; mEvt[0] = 1'b1; end
      default: mErr = 1'b1;
    endcase
    if (c[7]) begin
      mCu = 3'd0; mRu = 3'd1; mEvt = '0; mPtr = NUL; mIrq = 1'b0;
    end
    if (mCu != 3'd1 && mPtr == NUL) mPtr = head;
  endtask

  task automatic waitPublish(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (statusWe) begin seen = 1'b1; break; end
    end
  endtask

  // one CA service, checked against the model
  task automatic doCa(input logic [15:0] c, input logic [PTR_W-1:0] head);
    bit seen;
    @(negedge clk);
    cmdWord = c; listHead = head; caPulse = 1'b1;
    @(negedge clk);
    caPulse = 1'b0;
    check("R9 cmdClrWe low on pulse+1", {31'b0, cmdClrWe}, 32'd0);
    @(negedge clk);
    check("R9 cmdClrWe on pulse+2", {31'b0, cmdClrWe}, 32'd1);
    waitPublish(seen);
    check("R8 statusWe seen", {31'b0, seen}, 32'd1);
    modelCmd(c, head);
    check("R2/R3/R4/R5 statusWord", {16'b0, statusWord}, {16'b0, mStatus()});
    check("R7 cmdPtr", cmdPtr, mPtr);
    check("R10 errPulse", {31'b0, errPulse}, {31'b0, mErr});
    check("R6 softRst", {31'b0, softRst}, {31'b0, mRst});
    check("R12 startReq", {31'b0, startReq}, {31'b0, (mCu == 3'd2 && mPtr != NUL)});
    check("R11 irq", {31'b0, irq}, {31'b0, mIrq});
  endtask

  task automatic pulseEvent(input bit cx, input bit fr);
    @(negedge clk);
    cxEvent = cx; frEvent = fr;
    @(negedge clk);
    cxEvent = 1'b0; frEvent = 1'b0;
    if (cx) mEvt[3] = 1'b1;
    if (fr) mEvt[2] = 1'b1;
    if (cx || fr) mIrq = 1'b1;
    check("R13 event bits", {28'b0, statusWord[15:12]}, {28'b0, mEvt});
    check("R11 irq set", {31'b0, irq}, {31'b0, mIrq});
  endtask

  initial begin : watchdog
    #(1_500_000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin : main
    int cnt;
    logic [15:0] c;
    void'($urandom(32'd4711));
    mCu = 3'd0; mRu = 3'd1; mEvt = '0; mPtr = NUL; mIrq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset status", {16'b0, statusWord}, 32'h0010);
    check("R1 reset ptr", cmdPtr, NUL);
    check("R1 reset strobes", {28'b0, irq, statusWe, cmdClrWe, startReq}, 32'd0);

    // R2 start command unit, pointer loads (R7), start request (R12)
    doCa(16'h0100, 32'h0000_1000);
    // R7 pointer kept on a second command
    doCa(16'h0110, 32'h0000_2000);
    // R13/R11 external events, then R4 ack together with a new event
    pulseEvent(1'b1, 1'b1);
    doCa(16'hC400, 32'h0);       // ack CX+FR, abort CU -> bit13
    doCa(16'h2040, 32'h0);       // ack CNA, RU suspend -> bit12
    // R11 host clear
    @(negedge clk); irqClr = 1'b1; @(negedge clk); irqClr = 1'b0; mIrq = 1'b0;
    check("R11 irq cleared", {31'b0, irq}, 32'd0);
    // R7 release with CU suspended: no load
    @(negedge clk); ptrRelease = 1'b1; @(negedge clk); ptrRelease = 1'b0; mPtr = NUL;
    check("R7 release", cmdPtr, NUL);
    doCa(16'h0000, 32'h0000_3000);
    // R10 unknown codes
    doCa(16'h0300, 32'h0);
    doCa(16'h0070, 32'h0);
    // R6 soft reset combined with a start
    pulseEvent(1'b1, 1'b0);
    doCa(16'h0180, 32'h0000_4000);

    // R8 burst of three consecutive pulses
    @(negedge clk);
    cmdWord = 16'h0000; listHead = 32'h0000_5000;
    caPulse = 1'b1;
    repeat (3) @(negedge clk);
    caPulse = 1'b0;
    cnt = 0;
    if (statusWe) cnt++;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (statusWe) cnt++;
    end
    repeat (3) modelCmd(16'h0000, 32'h0000_5000);
    check("R8 burst services", cnt, 32'd3);
    check("R8 burst status", {16'b0, statusWord}, {16'b0, mStatus()});

    // constrained random
    for (int k = 0; k < 300; k++) begin
      c = 16'($urandom);
      case ($urandom % 4)
        0: c[10:8] = 3'd1;
        1: c[10:8] = 3'd4;
        2: c[10:8] = 3'd0;
        default: ;
      endcase
      c[7] = (($urandom % 8) == 0);
      if (($urandom % 5) == 0) pulseEvent($urandom % 2 == 1, $urandom % 2 == 1);
      if (($urandom % 6) == 0) begin
        @(negedge clk); ptrRelease = 1'b1; @(negedge clk); ptrRelease = 1'b0;
        mPtr = NUL;
      end
      if (($urandom % 6) == 0) begin
        @(negedge clk); irqClr = 1'b1; @(negedge clk); irqClr = 1'b0;
        mIrq = 1'b0;
      end
      doCa(c, $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule